// File: doc/BRIEF.md
# Log PCM code formatter

This block converts between signed linear audio samples and 8-bit companded PCM codes, in both directions, for either the mu-law or the A-law companding curve. Each code holds a sign, a 3-bit chord (segment) and a 4-bit step inside that chord. Before the code is sent on the serial bus, one of three line formats is applied: plain sign-magnitude, inverted magnitude, or inversion of the even-numbered bits. The law and the line format are chosen separately, so any law can be combined with any format.

The encode path takes a linear sample and returns a code. The decode path takes a code and returns the linear reconstruction level, which is the centre of the decision interval that the encoder maps to that code. This means that decoding a code and encoding the result again gives back a code that decodes to the same value. Each path has a valid strobe and is registered once. The two paths are independent and may run in the same cycle.

Top module: `pcm_code_fmt`

## Requirements
- R1: Code layout after line-format removal: bit 7 is the sign (1 = positive or zero, 0 = negative), bits [6:4] are the chord C and bits [3:0] are the step S. Format 0 (`fmt`=0) sends this plain code unchanged.
- R2: Format 1 XORs the plain code with 8'h7F, so the sign stays true and the seven magnitude bits are inverted. The decoder removes the same mask.
- R3: Format 2 XORs the plain code with 8'h55, which inverts bits 0, 2, 4 and 6. The decoder removes the same mask.
- R4: Format 3 behaves exactly like format 0. The format choice does not depend on the law (`law`=0 selects mu-law, `law`=1 selects A-law).
- R5: mu-law encode: the input is 14-bit two's complement. The magnitude is clipped to 8158 and 33 is added. The chord is the position of the leading one minus 5. The step is the four bits just below that leading one.
- R6: A-law encode: the input is the 13-bit two's complement value in `enc_sample_i[12:0]`. The magnitude is clipped to 4095. Below 32, the chord is 0 and the step is magnitude[4:1]. Otherwise, the chord is the leading-one position minus 4 and the step is the four bits below that leading one.
- R7: mu-law decode returns ((2S+33)·2^C) − 33, negated when the sign bit is 0. Full scale (C=7, S=15) gives ±8031.
- R8: A-law decode returns 2S+1 for C=0 and (2S+33)·2^(C−1) for C>0, negated when the sign bit is 0, and sign-extended to 14 bits. Full scale gives ±4032.
- R9: Each output valid goes high exactly one cycle after its input valid. An output value changes only on a cycle that follows an accepted input, and otherwise it holds.
- R10: During and after reset, before any input is accepted, both valids are 0 and both output values are 0.
- R11: For every code, law and format, encoding the decoded value gives a code that decodes to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| law | input | 1 | 0 = mu-law, 1 = A-law |
| fmt | input | 2 | Line format: 0 plain, 1 inverted magnitude, 2 even-bit inversion, 3 plain |
| enc_valid_i | input | 1 | Encode request |
| enc_sample_i | input | 14 | Linear sample, two's complement (A-law uses bits [12:0]) |
| enc_valid_o | output | 1 | Encoded code valid |
| enc_code_o | output | 8 | Line-formatted PCM code |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | 8 | Line-formatted PCM code |
| dec_valid_o | output | 1 | Decoded sample valid |
| dec_sample_o | output | 14 | Reconstructed linear sample, two's complement |

## Verification
The hardest cases to reach from the ports are the edges of the number range. These are the most negative input, whose magnitude needs one bit more than the range it is clipped to; the clip thresholds themselves; and the negative-zero code, which decodes to 0 and then encodes again as positive zero. The directed tasks drive these extremes for each law, and then sweep all 256 codes through decode, encode and decode again under every law and format pair. This makes every chord boundary and every mask pattern appear at the ports.

// File: rtl/pcm_code_fmt.sv
module pcm_code_fmt #(
  parameter int LinW    = 14,
  parameter int MuBias  = 33,
  parameter int MuClip  = 8158,
  parameter int AClip   = 4095
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            law,
  input  logic [1:0]      fmt,
  input  logic            enc_valid_i,
  input  logic [LinW-1:0] enc_sample_i,
  output logic            enc_valid_o,
  output logic [7:0]      enc_code_o,
  input  logic            dec_valid_i,
  input  logic [7:0]      dec_code_i,
  output logic            dec_valid_o,
  output logic [LinW-1:0] dec_sample_o
);

  logic [7:0] mask;
  always_comb begin
    case (fmt)
      2'd1:    mask = 8'h7F;
      2'd2:    mask = 8'h55;
      default: mask = 8'h00;
    endcase
  end

  // encode
  logic [LinW-1:0] x, mag, clipd, biased;
  logic            neg;
  logic [2:0]      e_chord;
  logic [3:0]      e_step;
  logic [LinW-1:0] e_shift;

  assign x      = law ? {enc_sample_i[LinW-2], enc_sample_i[LinW-2:0]} : enc_sample_i;
  assign neg    = x[LinW-1];
  assign mag    = neg ? (~x + 1'b1) : x;
  assign clipd  = law ? ((mag > LinW'(AClip)) ? LinW'(AClip) : mag)
                      : ((mag > LinW'(MuClip)) ? LinW'(MuClip) : mag);
  assign biased = law ? clipd : clipd + LinW'(MuBias);

  always_comb begin
    e_chord = 3'd0;
    for (int i = 5; i < 13; i++) begin
      if (law) begin
        if (i < 12 && biased[i]) e_chord = 3'(i - 4);
      end else begin
        if (biased[i]) e_chord = 3'(i - 5);
      end
    end
    if (law) e_shift = biased >> ((e_chord == 3'd0) ? 4'd1 : {1'b0, e_chord});
    else     e_shift = biased >> ({1'b0, e_chord} + 4'd1);
    e_step = e_shift[3:0];
  end

  // decode
  logic [7:0]      plain;
  logic [LinW-1:0] base, d_mag, d_val;
  assign plain = dec_code_i ^ mask;
  assign base  = LinW'({plain[3:0], 1'b1}) + LinW'(32);

  always_comb begin
    if (law) d_mag = (plain[6:4] == 3'd0) ? LinW'({plain[3:0], 1'b1})
                                          : (base << (plain[6:4] - 3'd1));
    else     d_mag = (base << plain[6:4]) - LinW'(MuBias);
    d_val = plain[7] ? d_mag : (~d_mag + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_valid_o  <= 1'b0;
      enc_code_o   <= '0;
      dec_valid_o  <= 1'b0;
      dec_sample_o <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      dec_valid_o <= dec_valid_i;
      if (enc_valid_i) enc_code_o <= {~neg, e_chord, e_step} ^ mask;
      if (dec_valid_i) dec_sample_o <= d_val;
    end
  end

  assert_enc_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_i |=> enc_valid_o);
  assert_dec_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !dec_valid_o);
  assert_enc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid_i |=> $stable(enc_code_o));
  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> $stable(dec_sample_o));
  assert_mu_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && !law) |=> ($signed(dec_sample_o) <= 14'sd8031 && $signed(dec_sample_o) >= -14'sd8031));
  assert_a_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && law) |=> ($signed(dec_sample_o) <= 14'sd4032 && $signed(dec_sample_o) >= -14'sd4032));
  assert_mu_fullscale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid_i && !law && fmt == 2'd0 && enc_sample_i == 14'h1FFF) |=> enc_code_o == 8'hFF);

endmodule

// File: tb/pcm_code_fmt_bench.sv
module pcm_code_fmt_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic law = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic enc_valid_i = 1'b0;
  logic [13:0] enc_sample_i = '0;
  logic enc_valid_o;
  logic [7:0] enc_code_o;
  logic dec_valid_i = 1'b0;
  logic [7:0] dec_code_i = '0;
  logic dec_valid_o;
  logic [13:0] dec_sample_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pcm_code_fmt u_pcm_code_fmt (
    .clk(clk), .rst_n(rst_n), .law(law), .fmt(fmt),
    .enc_valid_i(enc_valid_i), .enc_sample_i(enc_sample_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fmask(input int f);
    if (f == 1) return 8'h7F;
    if (f == 2) return 8'h55;
    return 0;
  endfunction

  function automatic int ref_dec(input int lw, input int f, input int code);
    int p, c, s, m;
    p = (code ^ fmask(f)) & 255;
    c = (p / 16) % 8;
    s = p % 16;
    if (lw == 0) m = (2 ** c) * (2 * s + 33) - 33;
    else if (c == 0) m = 2 * s + 1;
    else m = (2 ** (c - 1)) * (2 * s + 33);
    return (p >= 128) ? m : -m;
  endfunction

  function automatic int ref_enc(input int lw, input int f, input int v);
    int m, b, c, s, sg;
    sg = (v < 0) ? 0 : 1;
    m = (v < 0) ? -v : v;
    c = 7;
    if (lw == 0) begin
      if (m > 8158) m = 8158;
      b = m + 33;
      while (c > 0 && b < 32 * (2 ** c)) c--;
      s = (b / (2 ** (c + 1))) % 16;
    end else begin
      if (m > 4095) m = 4095;
      while (c > 0 && m < 16 * (2 ** c)) c--;
      s = (c == 0) ? (m / 2) % 16 : (m / (2 ** c)) % 16;
    end
    return ((sg * 128 + c * 16 + s) ^ fmask(f)) & 255;
  endfunction

  task automatic do_enc(input int lw, input int f, input int v, output int code);
    @(negedge clk);
    law = lw[0]; fmt = f[1:0];
    enc_sample_i = v[13:0]; enc_valid_i = 1'b1;
    @(negedge clk);
    check(enc_valid_o == 1'b1, "R9 enc valid", enc_valid_o, 1);
    code = enc_code_o;
    enc_valid_i = 1'b0;
  endtask

  task automatic do_dec(input int lw, input int f, input int code, output int v);
    @(negedge clk);
    law = lw[0]; fmt = f[1:0];
    dec_code_i = code[7:0]; dec_valid_i = 1'b1;
    @(negedge clk);
    check(dec_valid_o == 1'b1, "R9 dec valid", dec_valid_o, 1);
    v = $signed(dec_sample_o);
    dec_valid_i = 1'b0;
  endtask

  task automatic test_reset_r10();
    @(negedge clk);
    check(enc_valid_o == 0 && dec_valid_o == 0, "R10 valids in reset", enc_valid_o + dec_valid_o, 0);
    check(enc_code_o == 0 && dec_sample_o == 0, "R10 data in reset", enc_code_o + dec_sample_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(enc_valid_o == 0 && enc_code_o == 0, "R10 enc after reset", enc_code_o, 0);
    check(dec_valid_o == 0 && dec_sample_o == 0, "R10 dec after reset", dec_sample_o, 0);
  endtask

  task automatic test_mu_encode_r5();
    int c;
    do_enc(0, 0, 0, c);     check(c == 8'h80, "R5 R1 mu zero", c, 8'h80);
    do_enc(0, 0, 8191, c);  check(c == 8'hFF, "R5 mu full scale", c, 8'hFF);
    do_enc(0, 0, -8192, c); check(c == 8'h7F, "R5 mu most negative", c, 8'h7F);
    do_enc(0, 0, -1, c);    check(c == 8'h01, "R5 mu minus one", c, 8'h01);
    do_enc(0, 0, 8158, c);  check(c == 8'hFF, "R5 mu clip point", c, 8'hFF);
    do_enc(0, 0, 8030, c);  check(c == ref_enc(0, 0, 8030), "R5 mu chord 7", c, ref_enc(0, 0, 8030));
    do_enc(0, 0, 95, c);    check(c == 8'hA0, "R5 mu chord boundary", c, 8'hA0);
  endtask

  task automatic test_a_encode_r6();
    int c;
    do_enc(1, 0, 0, c);     check(c == 8'h80, "R6 A zero", c, 8'h80);
    do_enc(1, 0, 31, c);    check(c == 8'h8F, "R6 A top of chord 0", c, 8'h8F);
    do_enc(1, 0, 32, c);    check(c == 8'h90, "R6 A bottom of chord 1", c, 8'h90);
    do_enc(1, 0, 4095, c);  check(c == 8'hFF, "R6 A full scale", c, 8'hFF);
    do_enc(1, 0, -4096, c); check(c == 8'h7F, "R6 A most negative", c, 8'h7F);
    do_enc(1, 0, 1000, c);  check(c == ref_enc(1, 0, 1000), "R6 A mid", c, ref_enc(1, 0, 1000));
  endtask

  task automatic test_formats_r2_r3_r4();
    int c, v;
    do_enc(0, 1, 0, c);     check(c == 8'hFF, "R2 mu zero inverted magnitude", c, 8'hFF);
    do_enc(0, 1, 8191, c);  check(c == 8'h80, "R2 full scale inverted magnitude", c, 8'h80);
    do_enc(1, 2, 0, c);     check(c == 8'hD5, "R3 A zero even-bit inversion", c, 8'hD5);
    do_enc(1, 2, -4096, c); check(c == 8'h2A, "R3 A negative full scale", c, 8'h2A);
    do_enc(0, 2, 0, c);     check(c == 8'hD5, "R3 R4 mu with even-bit inversion", c, 8'hD5);
    do_enc(1, 1, 4095, c);  check(c == 8'h80, "R2 R4 A with inverted magnitude", c, 8'h80);
    do_enc(0, 3, -1, c);    check(c == 8'h01, "R4 format 3 as plain", c, 8'h01);
    do_dec(1, 3, 8'hFF, v); check(v == 4032, "R4 format 3 decode", v, 4032);
  endtask

  task automatic test_decode_r7_r8();
    int v;
    do_dec(0, 0, 8'hFF, v); check(v == 8031, "R7 mu full scale", v, 8031);
    do_dec(0, 0, 8'h7F, v); check(v == -8031, "R7 mu negative full scale", v, -8031);
    do_dec(0, 0, 8'h00, v); check(v == 0, "R7 mu negative zero", v, 0);
    do_dec(0, 1, 8'h80, v); check(v == 8031, "R7 R2 mu inverted full scale", v, 8031);
    do_dec(1, 0, 8'h80, v); check(v == 1, "R8 A smallest", v, 1);
    do_dec(1, 0, 8'h00, v); check(v == -1, "R8 A negative smallest", v, -1);
    do_dec(1, 0, 8'h90, v); check(v == 33, "R8 A chord 1", v, 33);
    do_dec(1, 2, 8'h2A, v); check(v == -4032, "R8 R3 A negative full scale", v, -4032);
  endtask

  task automatic test_hold_r9();
    int c0, v0;
    do_enc(0, 0, 100, c0);
    do_dec(0, 0, 8'hC5, v0);
    @(negedge clk);
    enc_sample_i = 14'd5000; dec_code_i = 8'h11;
    @(negedge clk);
    @(negedge clk);
    check(enc_valid_o == 0, "R9 enc valid low when idle", enc_valid_o, 0);
    check(dec_valid_o == 0, "R9 dec valid low when idle", dec_valid_o, 0);
    check(enc_code_o == c0[7:0], "R9 enc code holds", enc_code_o, c0);
    check($signed(dec_sample_o) == v0, "R9 dec sample holds", $signed(dec_sample_o), v0);
  endtask

  task automatic test_roundtrip_r11();
    int v, c2, v2;
    for (int lw = 0; lw < 2; lw++)
      for (int f = 0; f < 4; f++)
        for (int code = 0; code < 256; code++) begin
          do_dec(lw, f, code, v);
          check(v == ref_dec(lw, f, code), "R7 R8 sweep decode", v, ref_dec(lw, f, code));
          do_enc(lw, f, v, c2);
          check(c2 == ref_enc(lw, f, v), "R5 R6 sweep encode", c2, ref_enc(lw, f, v));
          do_dec(lw, f, c2, v2);
          check(v2 == v, "R11 round trip", v2, v);
        end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_r10();
    test_mu_encode_r5();
    test_a_encode_r6();
    test_formats_r2_r3_r4();
    test_decode_r7_r8();
    test_hold_r9();
    test_roundtrip_r11();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule